// File: doc/BRIEF.md
# Line-Wide Request Bus to AXI Bridge

This block connects a processor's simple valid/ready data request port to an AXI manager port whose data path is one 256-bit line wide. Each request carries an address, a write flag, a full line of write data and a 32-bit byte mask. The bridge turns each request into one single-beat AXI transaction. A read becomes one AR followed by one R beat. A write becomes a joint AW+W issue followed by one B response. The bridge allows only one transaction in flight.

A state machine drives the bridge. It has five states. `ST_IDLE` waits for a request. `ST_RD_ADDR` drives AR valid. `ST_RD_DATA` drives R ready. `ST_WR_ISSUE` drives AW valid and W valid together. `ST_WR_RESP` drives B ready. The transitions are:
- idle→rd_addr on a read request.
- idle→wr_issue on a write request.
- rd_addr→rd_data on the AR handshake.
- rd_data→idle on the R handshake.
- wr_issue→wr_resp when AW ready and W ready are both high.
- wr_resp→idle on B valid.

The R beat's line is registered and held on the requester's read-data output until the next read completes. The AXI address is the request address aligned down to a line. The write data and byte mask pass through to W unchanged. The response codes and IDs that come back are absorbed.

Top module: `line_axi_bridge`

## Requirements
- R1: In reset and in the first cycle after it, `axi_arvalid`, `axi_awvalid`, `axi_wvalid`, `axi_rready`, `axi_bready` and `req_ready` are low, and `req_rdata` is all zeros.
- R2: Whenever `axi_arvalid` or `axi_awvalid` is high, the address on that channel equals `req_addr` with bits [4:0] cleared, and its ID is zero.
- R3: `axi_awvalid` and `axi_wvalid` are always equal. A write issue completes only in a cycle where `axi_awready` and `axi_wready` are both high. With only one of them high, both valids stay up.
- R4: While `axi_wvalid` is high, `axi_wdata` equals `req_wdata` and `axi_wstrb` equals `req_bmask`.
- R5: For a write, `req_ready` is high exactly in the cycle of the joint AW/W handshake. In the following cycles `axi_bready` is high until `axi_bvalid` is seen, and then the bridge is idle again.
- R6: A read request seen while idle raises `axi_arvalid` from the next cycle until `axi_arready`. Then `axi_rready` is high until `axi_rvalid`. `req_ready` is high exactly in that R handshake cycle.
- R7: In the cycle after the R handshake, `req_rdata` equals the `axi_rdata` taken at that handshake. It holds that value until the next R handshake.
- R8: The values of `axi_rresp`, `axi_rid`, `axi_bresp` and `axi_bid` have no effect on `req_rdata` or on any control output.
- R9: At most one of `axi_arvalid`, `axi_rready`, `axi_awvalid` and `axi_bready` is high in any cycle. Each accepted read request produces exactly one AR handshake. No request is accepted while a B response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 256 | Line write data |
| req_bmask | input | 32 | Byte enables of the write line |
| req_ready | output | 1 | Request completed this cycle |
| req_rdata | output | 256 | Registered read line |
| axi_arvalid | output | 1 | AR valid |
| axi_arready | input | 1 | AR ready |
| axi_araddr | output | 32 | AR address, line aligned |
| axi_arid | output | 6 | AR ID, always zero |
| axi_rvalid | input | 1 | R valid |
| axi_rready | output | 1 | R ready |
| axi_rdata | input | 256 | R data |
| axi_rid | input | 6 | R ID, absorbed |
| axi_rresp | input | 2 | R response code, absorbed |
| axi_awvalid | output | 1 | AW valid |
| axi_awready | input | 1 | AW ready |
| axi_awaddr | output | 32 | AW address, line aligned |
| axi_awid | output | 6 | AW ID, always zero |
| axi_wvalid | output | 1 | W valid |
| axi_wready | input | 1 | W ready |
| axi_wdata | output | 256 | W data |
| axi_wstrb | output | 32 | W strobes |
| axi_bvalid | input | 1 | B valid |
| axi_bready | output | 1 | B ready |
| axi_bid | input | 6 | B ID, absorbed |
| axi_bresp | input | 2 | B response code, absorbed |

## Verification
Some results are due in the same cycle as their cause:
- The control outputs, `req_ready` and the AXI address and data fields follow from the present state and the current inputs.
- A new request raises AR valid or AW/W valid one edge after it is first seen while idle.
- The read line appears on `req_rdata` one edge after the R handshake.

The bench keeps a behavioural expectation that it advances at each rising edge from the inputs it drove. It compares every output at the falling edge, which places each of these latencies at its exact cycle. The bench drives AW ready and W ready independently, so cycles where only one of them is high occur.

// File: rtl/lab_pkg.sv
package lab_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ADDR  = 3'd1,
        ST_RD_DATA  = 3'd2,
        ST_WR_ISSUE = 3'd3,
        ST_WR_RESP  = 3'd4
    } lab_state_e;

endpackage

// File: rtl/lab_line_align.sv
module lab_line_align #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 5
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    // Clear the in-line byte offset, keep the line number.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i < OFS_W) begin : g_clr
            assign addr_out[i] = 1'b0;
        end else begin : g_keep
            assign addr_out[i] = addr_in[i];
        end
    end
endmodule

// File: rtl/lab_rdata_hold.sv
module lab_rdata_hold #(
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (capture) begin
            q <= d;
        end
    end
endmodule

// File: rtl/lab_fsm.sv
module lab_fsm
    import lab_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_write,
    input  logic arready,
    input  logic rvalid,
    input  logic awready,
    input  logic wready,
    input  logic bvalid,
    output logic arvalid,
    output logic rready,
    output logic awvalid,
    output logic wvalid,
    output logic bready,
    output logic req_ready,
    output logic rd_capture
);
    lab_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = req_write ? ST_WR_ISSUE : ST_RD_ADDR;
                end
            end
            ST_RD_ADDR: begin
                if (arready) state_d = ST_RD_DATA;
            end
            ST_RD_DATA: begin
                if (rvalid) state_d = ST_IDLE;
            end
            ST_WR_ISSUE: begin
                if (awready && wready) state_d = ST_WR_RESP;
            end
            ST_WR_RESP: begin
                if (bvalid) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        arvalid    = 1'b0;
        rready     = 1'b0;
        awvalid    = 1'b0;
        wvalid     = 1'b0;
        bready     = 1'b0;
        req_ready  = 1'b0;
        rd_capture = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_ADDR: arvalid = 1'b1;
            ST_RD_DATA: begin
                rready     = 1'b1;
                rd_capture = rvalid;
                req_ready  = rvalid;
            end
            ST_WR_ISSUE: begin
                awvalid   = 1'b1;
                wvalid    = 1'b1;
                req_ready = awready && wready;
            end
            ST_WR_RESP: bready = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/line_axi_bridge.sv
module line_axi_bridge #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int ID_W       = 6,
    localparam int DATA_W    = LINE_BYTES * 8,
    localparam int OFS_W     = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LINE_BYTES-1:0] req_bmask,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic              axi_arvalid,
    input  logic              axi_arready,
    output logic [ADDR_W-1:0] axi_araddr,
    output logic [ID_W-1:0]   axi_arid,
    input  logic              axi_rvalid,
    output logic              axi_rready,
    input  logic [DATA_W-1:0] axi_rdata,
    input  logic [ID_W-1:0]   axi_rid,
    input  logic [1:0]        axi_rresp,
    output logic              axi_awvalid,
    input  logic              axi_awready,
    output logic [ADDR_W-1:0] axi_awaddr,
    output logic [ID_W-1:0]   axi_awid,
    output logic              axi_wvalid,
    input  logic              axi_wready,
    output logic [DATA_W-1:0] axi_wdata,
    output logic [LINE_BYTES-1:0] axi_wstrb,
    input  logic              axi_bvalid,
    output logic              axi_bready,
    input  logic [ID_W-1:0]   axi_bid,
    input  logic [1:0]        axi_bresp
);
    logic              rd_capture;
    logic [ADDR_W-1:0] line_addr;

    // Response codes and IDs are taken and discarded.
    logic unused_resp;
    assign unused_resp = ^{axi_rid, axi_rresp, axi_bid, axi_bresp};

    lab_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .arready    (axi_arready),
        .rvalid     (axi_rvalid),
        .awready    (axi_awready),
        .wready     (axi_wready),
        .bvalid     (axi_bvalid),
        .arvalid    (axi_arvalid),
        .rready     (axi_rready),
        .awvalid    (axi_awvalid),
        .wvalid     (axi_wvalid),
        .bready     (axi_bready),
        .req_ready  (req_ready),
        .rd_capture (rd_capture)
    );

    lab_line_align #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_align (
        .addr_in  (req_addr),
        .addr_out (line_addr)
    );

    lab_rdata_hold #(
        .DATA_W (DATA_W)
    ) u_rhold (
        .clk     (clk),
        .rst     (rst),
        .capture (rd_capture),
        .d       (axi_rdata),
        .q       (req_rdata)
    );

    assign axi_araddr = line_addr;
    assign axi_awaddr = line_addr;
    assign axi_arid   = '0;
    assign axi_awid   = '0;
    assign axi_wdata  = req_wdata;
    assign axi_wstrb  = req_bmask;
endmodule

// File: rtl/lab_bridge_chk.sv
module lab_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 256,
    parameter int ID_W   = 6,
    parameter int OFS_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic [DATA_W-1:0] req_rdata,
    input logic              axi_arvalid,
    input logic              axi_arready,
    input logic [ADDR_W-1:0] axi_araddr,
    input logic [ID_W-1:0]   axi_arid,
    input logic              axi_rvalid,
    input logic              axi_rready,
    input logic [DATA_W-1:0] axi_rdata,
    input logic              axi_awvalid,
    input logic              axi_awready,
    input logic [ADDR_W-1:0] axi_awaddr,
    input logic [ID_W-1:0]   axi_awid,
    input logic              axi_wvalid,
    input logic              axi_wready,
    input logic              axi_bready
);
    AST_AR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        axi_arvalid |-> (axi_araddr[OFS_W-1:0] == '0 && axi_arid == '0)); // R2
    AST_AW_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        axi_awvalid |-> (axi_awaddr[OFS_W-1:0] == '0 && axi_awid == '0)); // R2
    AST_AW_W_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        axi_awvalid == axi_wvalid); // R3
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (axi_awvalid && !(axi_awready && axi_wready)) |=> axi_awvalid); // R3
    AST_WR_TO_BRESP: assert property (@(posedge clk) disable iff (rst)
        (axi_awvalid && axi_awready && axi_wready) |=> axi_bready); // R5
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (axi_arvalid && !axi_arready) |=> axi_arvalid); // R6
    AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ((axi_rvalid && axi_rready) ||
                       (axi_awvalid && axi_awready && axi_wready))); // R6
    AST_RDATA_NEXT: assert property (@(posedge clk) disable iff (rst)
        (axi_rvalid && axi_rready) |=> (req_rdata == $past(axi_rdata))); // R7
    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({axi_arvalid, axi_rready, axi_awvalid, axi_bready})); // R9
    AST_NO_ACCEPT_IN_BRESP: assert property (@(posedge clk) disable iff (rst)
        axi_bready |-> !req_ready); // R9
endmodule

bind line_axi_bridge lab_bridge_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .OFS_W  (OFS_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .req_rdata   (req_rdata),
    .axi_arvalid (axi_arvalid),
    .axi_arready (axi_arready),
    .axi_araddr  (axi_araddr),
    .axi_arid    (axi_arid),
    .axi_rvalid  (axi_rvalid),
    .axi_rready  (axi_rready),
    .axi_rdata   (axi_rdata),
    .axi_awvalid (axi_awvalid),
    .axi_awready (axi_awready),
    .axi_awaddr  (axi_awaddr),
    .axi_awid    (axi_awid),
    .axi_wvalid  (axi_wvalid),
    .axi_wready  (axi_wready),
    .axi_bready  (axi_bready)
);

// File: tb/line_axi_bridge_bench.sv
`timescale 1ns/1ps
module line_axi_bridge_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 0, req_write = 0;
    logic [31:0]  req_addr = 0;
    logic [255:0] req_wdata = 0;
    logic [31:0]  req_bmask = 0;
    logic         req_ready;
    logic [255:0] req_rdata;
    logic         axi_arvalid, axi_arready = 0;
    logic [31:0]  axi_araddr;
    logic [5:0]   axi_arid;
    logic         axi_rvalid = 0, axi_rready;
    logic [255:0] axi_rdata = 0;
    logic [5:0]   axi_rid = 0;
    logic [1:0]   axi_rresp = 0;
    logic         axi_awvalid, axi_awready = 0;
    logic [31:0]  axi_awaddr;
    logic [5:0]   axi_awid;
    logic         axi_wvalid, axi_wready = 0;
    logic [255:0] axi_wdata;
    logic [31:0]  axi_wstrb;
    logic         axi_bvalid = 0, axi_bready;
    logic [5:0]   axi_bid = 0;
    logic [1:0]   axi_bresp = 0;

    always #2.5 clk = ~clk;

    line_axi_bridge u_line_axi_bridge (.*);

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] rnd_line();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // Behavioural expectation: 0 idle, 1 awaiting AR, 2 awaiting R, 3 write issue, 4 awaiting B.
    int           phase = 0;
    logic [255:0] exp_line = '0;
    logic [255:0] rq[$];
    int           bq = 0;
    int           rd_accepted = 0, ar_seen = 0, completed = 0;

    task automatic compare_all();
        logic e_ready;
        e_ready = (phase == 2 && axi_rvalid) || (phase == 3 && axi_awready && axi_wready);
        chk("R6 arvalid", axi_arvalid, phase == 1);
        chk("R6 rready", axi_rready, phase == 2);
        chk("R3 awvalid", axi_awvalid, phase == 3);
        chk("R3 wvalid", axi_wvalid, phase == 3);
        chk("R5 bready", axi_bready, phase == 4);
        chk("R5 req_ready", req_ready, e_ready);
        chk("R7 R8 req_rdata", req_rdata, exp_line);
        if (phase == 1) begin
            chk("R2 araddr", axi_araddr, {req_addr[31:5], 5'b0});
            chk("R2 arid", axi_arid, 0);
        end
        if (phase == 3) begin
            chk("R2 awaddr", axi_awaddr, {req_addr[31:5], 5'b0});
            chk("R2 awid", axi_awid, 0);
            chk("R4 wdata", axi_wdata, req_wdata);
            chk("R4 wstrb", axi_wstrb, req_bmask);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        chk("R1 arvalid", axi_arvalid, 0);
        chk("R1 awvalid", axi_awvalid, 0);
        chk("R1 wvalid", axi_wvalid, 0);
        chk("R1 rready", axi_rready, 0);
        chk("R1 bready", axi_bready, 0);
        chk("R1 req_ready", req_ready, 0);
        chk("R1 req_rdata", req_rdata, 0);
        rst = 0;
        for (int cyc = 0; cyc < 6000; cyc++) begin
            logic accept;
            @(posedge clk);
            // advance the expectation with the inputs present at this edge
            accept = 0;
            case (phase)
                0: if (req_valid) begin
                       phase = req_write ? 3 : 1;
                       if (!req_write) rd_accepted++;
                   end
                1: if (axi_arready) begin
                       phase = 2; ar_seen++;
                       rq.push_back(rnd_line());
                   end
                2: if (axi_rvalid) begin
                       exp_line = axi_rdata; accept = 1;
                       void'(rq.pop_front()); phase = 0; completed++;
                   end
                3: if (axi_awready && axi_wready) begin
                       accept = 1; bq++; phase = 4;
                   end
                4: if (axi_bvalid) begin
                       bq--; phase = 0; completed++;
                   end
                default: phase = 0;
            endcase
            #1;
            // requester: hold an unaccepted request, else pick a new one
            if (!(req_valid && !accept && phase != 0) || accept) begin
                if (accept || !req_valid || ($urandom % 4 == 0 && phase == 0)) begin
                    req_valid = ($urandom % 3) != 0;
                    req_write = $urandom % 2;
                    req_addr  = $urandom;
                    req_wdata = rnd_line();
                    req_bmask = $urandom;
                end
            end
            axi_arready = $urandom % 2;
            axi_awready = $urandom % 2;
            axi_wready  = $urandom % 2;
            axi_rvalid  = (rq.size() > 0) && ($urandom % 2);
            axi_rdata   = (rq.size() > 0) ? rq[0] : rnd_line();
            axi_rresp   = $urandom;
            axi_rid     = $urandom;
            axi_bvalid  = (bq > 0) && ($urandom % 2);
            axi_bresp   = $urandom;
            axi_bid     = $urandom;
            @(negedge clk);
            compare_all();
        end
        chk("R9 one AR per read", ar_seen + (phase == 1 ? 1 : 0), rd_accepted);
        chk("R9 progress", completed > 500, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule